// File: doc/BRIEF.md
# Programmable Bus Segment Repeater

This block joins two neighbouring segments of a routing channel that carries one local bus and one express bus. Each side of the repeater therefore has two segment ports, one local and one express. A static 5-bit connection code picks one of twenty-one functions. These are: keep everything apart, pass one segment onto another, or fan one segment out to two others. Every active link copies a chosen source segment onto a chosen destination segment in one direction only. The signal passes through a register stage that regenerates it.

Tristate segments are modelled as a value plus a drive flag. A destination is only driven when its route is selected and its source segment is actually being driven. A parameter picks the bus-pair variant. The second variant may also enable a two-way link between the two local segments. The purpose is long tristate lines: whichever local side is driven feeds the other side, and two drivers at once are flagged as a clash. Codes outside the table and two-way requests the variant cannot honour raise an illegal-configuration flag, and then nothing is driven.

Top module: `seg_repeater`

## Requirements
- R1: While rst_n is low, every output (seg_val_o, seg_oe_o, cfg_illegal_o, bidir_clash_o) is 0.
- R2: Segment bit indices are 0 = local side A, 1 = express side A, 2 = local side B, 3 = express side B. All outputs are registered and reflect the inputs sampled at the previous rising clock edge.
- R3: Code 0 drives no segment.
- R4: Code 1 copies local A to local B. Code 2 copies local B to local A.
- R5: Code 3 copies express A to express B. Code 4 copies express B to express A.
- R6: Codes 5..12 transfer between bus types: 5 LA→XA, 6 LB→XB, 7 XA→LA, 8 XB→LB, 9 LA→XB, 10 LB→XA, 11 XA→LB, 12 XB→LA.
- R7: Codes 13..16 fan source LA, LB, XA, XB respectively out to both segments of the opposite side. Codes 17..20 fan the same sources out to the same-type segment on the opposite side and the other-type segment on their own side.
- R8: An output-enable bit is 1 only when a selected route feeds that segment from a source whose drive flag was 1. A segment whose enable is 0 shows value 0.
- R9: Codes 21..31 set cfg_illegal_o and drive no segment.
- R10: With PAIR_SEL = 2, cfg_bidir = 1 and code 0, 3 or 4, a local segment whose drive flag is 1 while the other local's flag is 0 is copied onto the other local segment. The express route of the code still applies.
- R11: In the R10 mode, if both local drive flags are 1, bidir_clash_o is 1 and neither local segment is driven.
- R12: cfg_bidir = 1 with PAIR_SEL = 1, or with any code other than 0, 3 or 4, sets cfg_illegal_o and drives no segment. bidir_clash_o never rises when PAIR_SEL = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_code | input | 5 | Static connection function code |
| cfg_bidir | input | 1 | Request the two-way local link |
| seg_val_i | input | 4 | Value currently on each segment |
| seg_drv_i | input | 4 | Segment is being driven by something else |
| seg_val_o | output | 4 | Regenerated value this repeater drives |
| seg_oe_o | output | 4 | This repeater drives the segment |
| cfg_illegal_o | output | 1 | Configuration not legal for this variant |
| bidir_clash_o | output | 1 | Both local sides drove in two-way mode |

## Verification
A wrong entry in the route decode appears one clock later as an enable on the wrong segment, or as a value copied from the wrong source. It shows up on the first cycle whose drive pattern separates the two sources. A faulty legality or clash term shows in the same cycle as enables that should have stayed low or a flag of the wrong level. Because the bench sweeps every code with both settings of cfg_bidir and varied drive patterns, each such fault can be seen within a few cycles of its code being applied.

// File: rtl/rptr_pkg.sv
package rptr_pkg;
  localparam int SEG_N     = 4;
  localparam int SEG_W     = $clog2(SEG_N);
  localparam int CODE_W    = 5;
  localparam int LAST_CODE = 20;
  localparam int FAN_BASE  = 13;

  typedef struct packed {
    logic [SEG_N-1:0]            en;
    logic [SEG_N-1:0][SEG_W-1:0] src;
  } route_t;

  function automatic route_t add_link(input route_t r, input logic [SEG_W-1:0] s,
                                      input logic [SEG_W-1:0] d);
    route_t o;
    o = r;
    o.en[d]  = 1'b1;
    o.src[d] = s;
    return o;
  endfunction

  // Route table: indices 0=LA 1=XA 2=LB 3=XB; xor 2 = other side, xor 1 = other type
  function automatic route_t route_of(input logic [CODE_W-1:0] code);
    route_t r;
    logic [2:0] j;
    logic [SEG_W-1:0] s;
    r = '0;
    j = '0;
    s = '0;
    case (code)
      5'd1:  r = add_link(r, 2'd0, 2'd2);
      5'd2:  r = add_link(r, 2'd2, 2'd0);
      5'd3:  r = add_link(r, 2'd1, 2'd3);
      5'd4:  r = add_link(r, 2'd3, 2'd1);
      5'd5:  r = add_link(r, 2'd0, 2'd1);
      5'd6:  r = add_link(r, 2'd2, 2'd3);
      5'd7:  r = add_link(r, 2'd1, 2'd0);
      5'd8:  r = add_link(r, 2'd3, 2'd2);
      5'd9:  r = add_link(r, 2'd0, 2'd3);
      5'd10: r = add_link(r, 2'd2, 2'd1);
      5'd11: r = add_link(r, 2'd1, 2'd2);
      5'd12: r = add_link(r, 2'd3, 2'd0);
      default: begin
        if (code >= CODE_W'(FAN_BASE) && code <= CODE_W'(LAST_CODE)) begin
          j = 3'(code - CODE_W'(FAN_BASE));
          s = {j[0], j[1]};
          r = add_link(r, s, s ^ 2'd2);
          if (!j[2]) r = add_link(r, s, s ^ 2'd3);
          else       r = add_link(r, s, s ^ 2'd1);
        end
      end
    endcase
    return r;
  endfunction

  function automatic logic code_legal(input logic [CODE_W-1:0] code, input logic bidir,
                                      input logic bidir_ok);
    logic express_only;
    express_only = (code == 5'd0) || (code == 5'd3) || (code == 5'd4);
    return (code <= CODE_W'(LAST_CODE)) && (!bidir || (bidir_ok && express_only));
  endfunction
endpackage

// File: rtl/rptr_decode.sv
module rptr_decode
  import rptr_pkg::*;
#(
  parameter bit BIDIR_OK = 1'b1
) (
  input  logic [CODE_W-1:0] code,
  input  logic              bidir,
  output route_t            route,
  output logic              legal,
  output logic              bidir_on
);
  always_comb begin
    legal    = code_legal(code, bidir, BIDIR_OK);
    route    = legal ? route_of(code) : '0;
    bidir_on = legal & bidir;
  end
endmodule

// File: rtl/rptr_xbar.sv
module rptr_xbar
  import rptr_pkg::*;
(
  input  route_t           route,
  input  logic             bidir_on,
  input  logic [SEG_N-1:0] val_i,
  input  logic [SEG_N-1:0] drv_i,
  output logic [SEG_N-1:0] nxt_val,
  output logic [SEG_N-1:0] nxt_oe,
  output logic             nxt_clash
);
  logic [SEG_N-1:0] routed_hit;
  logic [SEG_N-1:0] peer_hit;

  assign nxt_clash = bidir_on & drv_i[0] & drv_i[2];

  for (genvar d = 0; d < SEG_N; d++) begin : g_dst
    localparam int PEER = d ^ 2;
    logic [SEG_W-1:0] sel;
    assign sel           = route.src[d];
    assign routed_hit[d] = route.en[d] & drv_i[sel];
    if (d % 2 == 0) begin : g_local
      assign peer_hit[d] = bidir_on & drv_i[PEER] & ~drv_i[d];
    end else begin : g_express
      assign peer_hit[d] = 1'b0;
    end
    assign nxt_oe[d]  = routed_hit[d] | peer_hit[d];
    assign nxt_val[d] = routed_hit[d] ? val_i[sel] :
                        peer_hit[d]   ? val_i[PEER] : 1'b0;
  end
endmodule

// File: rtl/rptr_regen.sv
module rptr_regen
  import rptr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEG_N-1:0] nxt_val,
  input  logic [SEG_N-1:0] nxt_oe,
  input  logic             nxt_illegal,
  input  logic             nxt_clash,
  output logic [SEG_N-1:0] val_q,
  output logic [SEG_N-1:0] oe_q,
  output logic             illegal_q,
  output logic             clash_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q     <= '0;
      oe_q      <= '0;
      illegal_q <= 1'b0;
      clash_q   <= 1'b0;
    end else begin
      val_q     <= nxt_val;
      oe_q      <= nxt_oe;
      illegal_q <= nxt_illegal;
      clash_q   <= nxt_clash;
    end
  end

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |-> (oe_q == '0));

  // R8
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((val_q & ~oe_q) == '0));

  // R11
  clash_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash_q |-> (!oe_q[0] && !oe_q[2]));
endmodule

// File: rtl/seg_repeater.sv
module seg_repeater
  import rptr_pkg::*;
#(
  parameter int PAIR_SEL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cfg_bidir,
  input  logic [SEG_N-1:0]  seg_val_i,
  input  logic [SEG_N-1:0]  seg_drv_i,
  output logic [SEG_N-1:0]  seg_val_o,
  output logic [SEG_N-1:0]  seg_oe_o,
  output logic              cfg_illegal_o,
  output logic              bidir_clash_o
);
  localparam bit BIDIR_OK = (PAIR_SEL == 2);

  route_t           route_w;
  logic             legal_w;
  logic             bidir_on_w;
  logic [SEG_N-1:0] nxt_val_w;
  logic [SEG_N-1:0] nxt_oe_w;
  logic             nxt_clash_w;

  rptr_decode #(.BIDIR_OK(BIDIR_OK)) u_decode (
    .code     (cfg_code),
    .bidir    (cfg_bidir),
    .route    (route_w),
    .legal    (legal_w),
    .bidir_on (bidir_on_w)
  );

  rptr_xbar u_xbar (
    .route     (route_w),
    .bidir_on  (bidir_on_w),
    .val_i     (seg_val_i),
    .drv_i     (seg_drv_i),
    .nxt_val   (nxt_val_w),
    .nxt_oe    (nxt_oe_w),
    .nxt_clash (nxt_clash_w)
  );

  rptr_regen u_regen (
    .clk         (clk),
    .rst_n       (rst_n),
    .nxt_val     (nxt_val_w),
    .nxt_oe      (nxt_oe_w),
    .nxt_illegal (~legal_w),
    .nxt_clash   (nxt_clash_w),
    .val_q       (seg_val_o),
    .oe_q        (seg_oe_o),
    .illegal_q   (cfg_illegal_o),
    .clash_q     (bidir_clash_o)
  );

  // R8
  drive_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_oe_o != '0) |-> $past(seg_drv_i != '0));

  // R7
  fanout_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_oe_o) <= 2);

  // R3
  isolate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_code == '0 && !cfg_bidir) |-> (seg_oe_o == '0));

  // R12
  first_pair_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !BIDIR_OK |-> !bidir_clash_o);
endmodule

// File: tb/seg_repeater_tb.sv
`timescale 1ns/100ps
module seg_repeater_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cfg_code = '0;
  logic       cfg_bidir = 1'b0;
  logic [3:0] seg_val_i = '0;
  logic [3:0] seg_drv_i = '0;
  logic [3:0] v2_o, e2_o, v1_o, e1_o;
  logic       ill2_o, cl2_o, ill1_o, cl1_o;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_repeater #(.PAIR_SEL(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code), .cfg_bidir(cfg_bidir),
    .seg_val_i(seg_val_i), .seg_drv_i(seg_drv_i), .seg_val_o(v2_o),
    .seg_oe_o(e2_o), .cfg_illegal_o(ill2_o), .bidir_clash_o(cl2_o));

  seg_repeater #(.PAIR_SEL(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code), .cfg_bidir(cfg_bidir),
    .seg_val_i(seg_val_i), .seg_drv_i(seg_drv_i), .seg_val_o(v1_o),
    .seg_oe_o(e1_o), .cfg_illegal_o(ill1_o), .bidir_clash_o(cl1_o));

  function automatic int seg(input int side, input int kind);
    return side * 2 + kind;
  endfunction

  // Behavioural model: list of (source, destination) links per code
  task automatic model(input int variant, input int code, input bit bid,
                       input logic [3:0] v, input logic [3:0] d,
                       output logic [9:0] packed_exp);
    int srcs[$];
    int dsts[$];
    logic [3:0] ev, eo;
    logic eill, ecl;
    ev = '0; eo = '0; ecl = 1'b0;
    eill = !(code <= 20 && (!bid || (variant == 2 && (code == 0 || code == 3 || code == 4))));
    if (!eill) begin
      if (code >= 1 && code <= 12) begin
        int p, m;
        p = (code - 1) / 2;
        m = (code - 1) % 2;
        case (p)
          0: begin srcs.push_back(seg(m, 0)); dsts.push_back(seg(1 - m, 0)); end
          1: begin srcs.push_back(seg(m, 1)); dsts.push_back(seg(1 - m, 1)); end
          2: begin srcs.push_back(seg(m, 0)); dsts.push_back(seg(m, 1)); end
          3: begin srcs.push_back(seg(m, 1)); dsts.push_back(seg(m, 0)); end
          4: begin srcs.push_back(seg(m, 0)); dsts.push_back(seg(1 - m, 1)); end
          default: begin srcs.push_back(seg(m, 1)); dsts.push_back(seg(1 - m, 0)); end
        endcase
      end else if (code >= 13) begin
        int j, kind, side;
        j = code - 13;
        kind = (j % 4) / 2;
        side = j % 2;
        srcs.push_back(seg(side, kind)); dsts.push_back(seg(1 - side, kind));
        srcs.push_back(seg(side, kind));
        if (j < 4) dsts.push_back(seg(1 - side, 1 - kind));
        else       dsts.push_back(seg(side, 1 - kind));
      end
      foreach (srcs[i]) if (d[srcs[i]]) begin
        eo[dsts[i]] = 1'b1;
        ev[dsts[i]] = v[srcs[i]];
      end
      if (bid) begin
        if (d[0] && d[2]) ecl = 1'b1;
        else if (d[0]) begin eo[2] = 1'b1; ev[2] = v[0]; end
        else if (d[2]) begin eo[0] = 1'b1; ev[0] = v[2]; end
      end
    end
    packed_exp = {ev, eo, eill, ecl};
  endtask

  function automatic string tag_for(input int variant, input int code, input bit bid,
                                    input logic [3:0] d);
    if (code > 20) return "R9";
    if (bid) begin
      if (variant == 1 || !(code == 0 || code == 3 || code == 4)) return "R12";
      if (d[0] && d[2]) return "R11";
      return "R10";
    end
    if (code == 0) return "R3";
    if (code <= 2) return "R4";
    if (code <= 4) return "R5";
    if (code <= 12) return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual={val,oe,ill,clash}=%b expected=%b", tag, act, exp);
    end
  endtask

  // Model from current inputs, apply next inputs after the edge, then compare
  task automatic run_cycle(input logic [4:0] nc, input bit nb,
                           input logic [3:0] nv, input logic [3:0] nd, input string extra);
    logic [9:0] x2, x1;
    string t2, t1;
    model(2, int'(cfg_code), cfg_bidir, seg_val_i, seg_drv_i, x2);
    model(1, int'(cfg_code), cfg_bidir, seg_val_i, seg_drv_i, x1);
    t2 = {tag_for(2, int'(cfg_code), cfg_bidir, seg_drv_i), extra};
    t1 = {tag_for(1, int'(cfg_code), cfg_bidir, seg_drv_i), extra};
    @(posedge clk);
    #1;
    cfg_code = nc; cfg_bidir = nb; seg_val_i = nv; seg_drv_i = nd;
    #2;
    // R2: outputs still carry the previous edge's inputs after the new ones arrive
    check({t2, " R2"}, {v2_o, e2_o, ill2_o, cl2_o}, x2);
    check({t1, " R2"}, {v1_o, e1_o, ill1_o, cl1_o}, x1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    cfg_code = 5'd1; seg_drv_i = 4'hF; seg_val_i = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds every output low despite active inputs
    check("R1", {v2_o, e2_o, ill2_o, cl2_o}, '0);
    check("R1", {v1_o, e1_o, ill1_o, cl1_o}, '0);
    rst_n = 1'b1;
    cfg_code = '0; seg_drv_i = '0;
    // R8: routed code but undriven source gives no drive
    run_cycle(5'd1, 1'b0, 4'b0001, 4'b0000, " R8");
    run_cycle(5'd1, 1'b0, 4'b0001, 4'b0001, " R8");
    run_cycle(5'd0, 1'b1, 4'b0000, 4'b0101, " R4");
    for (int c = 0; c < 32; c++) begin
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k < 6; k++) begin
          logic [3:0] nd;
          case (k)
            0: nd = 4'b0101;
            1: nd = 4'b0000;
            2: nd = 4'b1111;
            default: nd = 4'($urandom);
          endcase
          run_cycle(5'(c), b[0], 4'($urandom), nd, "");
        end
      end
    end
    run_cycle(5'd0, 1'b0, 4'b0000, 4'b0000, "");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule